// File: doc/BRIEF.md
# Windowed Register File with Call/Return Rotation

This block is a register file whose visible set of 32 registers slides over a larger physical store on every procedure call and return. Eight registers (numbers 0 to 7) are shared by all procedures, with register 0 fixed at zero. The other 24 registers form the current window. That window has three 8-register areas: incoming arguments, private locals and outgoing arguments. Consecutive windows overlap. The outgoing area of one window is the same storage as the incoming area of the next, so a caller hands arguments to its callee without copying them.

A current window pointer picks the active window from a ring of eight windows. A saved window pointer marks the oldest window still held on chip. A call that would reuse a window not yet saved is refused, and the block raises an overflow trap naming the window that must be saved. A return into a window already sent to memory is also refused, and the block raises an underflow trap naming the window that must be brought back. Software moves the data. It then pulses a spill or fill acknowledge, which moves the saved pointer by one window, and re-issues the refused call or return.

Top module: `rwin_file`

## Requirements
- R1: After reset the current and saved window pointers are 0, both trap outputs are low, and every register reads 0.
- R2: Register 0 always reads 0. A write to register 0 has no effect.
- R3: Registers 1 to 7 are one physical set, seen unchanged from every window.
- R4: In window w, registers 8–15 (incoming), 16–23 (local) and 24–31 (outgoing) map to physical window offsets 0–7, 8–15 and 16–23 of a 16-register slot at base 16·w. This makes register 24+k of window w the same storage as register 8+k of window w+1.
- R5: An accepted call adds 1 to the current window pointer and an accepted return subtracts 1, both modulo 8. The new pointer is visible on the cycle after the strobe.
- R6: Local registers 16–23 of one window are not visible from the adjacent windows.
- R7: At most 7 windows may be resident. A call made when 7 are resident is refused: the pointer holds, and `ovf_trap` pulses high for one cycle with `trap_win` equal to the oldest resident window, which is the saved window pointer.
- R8: An accepted spill acknowledge adds 1 to the saved window pointer and an accepted fill acknowledge subtracts 1, both modulo 8. A spill is ignored when only one window is resident. A fill is ignored when 7 are resident.
- R9: A return made when only the current window is resident is refused: the pointer holds, and `unf_trap` pulses high for one cycle with `trap_win` equal to the current pointer minus 1.
- R10: An acknowledge in the same cycle as a call or return is applied first. A call at 7 resident windows together with a spill acknowledge is accepted. A return at 1 resident window together with a fill acknowledge is accepted.
- R11: Call and return asserted together are both ignored. Spill and fill asserted together are both ignored.
- R12: A read of the physical register being written in the same cycle returns the new write data on both read ports.
- R13: The window ring wraps. The outgoing registers of window 7 are the incoming registers of window 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_addr | input | 5 | Architectural address, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_addr | input | 5 | Architectural address, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural write address |
| wr_data | input | 32 | Write data |
| call_req | input | 1 | Call strobe |
| ret_req | input | 1 | Return strobe |
| spill_ack | input | 1 | One window has been saved to memory |
| fill_ack | input | 1 | One window has been restored from memory |
| ovf_trap | output | 1 | One-cycle pulse: call refused, a window must be saved |
| unf_trap | output | 1 | One-cycle pulse: return refused, a window must be restored |
| trap_win | output | 3 | Window the last trap refers to |
| cwp_o | output | 3 | Current window pointer |
| swp_o | output | 3 | Saved window pointer (oldest resident window) |

## Verification
The interesting overlap is a spill or fill acknowledge arriving in the same cycle as a call or return that would otherwise trap. The vector walk drives a call together with a spill acknowledge while seven windows are resident. It also drives a return together with a fill acknowledge while one window is resident. In both cases it expects the call or return to be accepted with no trap. The same walk checks that the refusals still happen when each strobe arrives alone, and that contradictory strobe pairs change nothing.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

  // Pointer events decided in one cycle by the window controller.
  typedef struct packed {
    logic call_ok;
    logic ret_ok;
    logic spill_ok;
    logic fill_ok;
    logic ovf_hit;
    logic unf_hit;
  } win_evt_t;

endpackage

// File: rtl/rwin_xlate.sv
module rwin_xlate #(
  parameter int NWIN = 8,
  parameter int AREA = 8,
  parameter int CW   = $clog2(NWIN),
  parameter int AW   = $clog2(4*AREA),
  parameter int PW   = $clog2(AREA + NWIN*2*AREA)
) (
  input  logic [CW-1:0] cwp,
  input  logic [AW-1:0] arch_addr,
  output logic [PW-1:0] phys_idx
);
  localparam int SLOT     = 2*AREA;
  localparam int WIN_PHYS = NWIN*SLOT;

  // Shared registers sit at the bottom of the flat store; windowed ones
  // follow, rotated by the slot base of the current window.
  function automatic logic [PW-1:0] phys_of(input logic [CW-1:0] w,
                                            input logic [AW-1:0] a);
    int unsigned rel;
    if (int'(a) < AREA) return PW'(a);
    rel = (int'(w)*SLOT + int'(a) - AREA) % WIN_PHYS;
    return PW'(AREA + rel);
  endfunction

  assign phys_idx = phys_of(cwp, arch_addr);

endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int DW    = 32,
  parameter int NPHYS = 136,
  parameter int PW    = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_a_idx,
  input  logic [PW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_a_data,
  output logic [DW-1:0] rd_b_data
);
  logic [DW-1:0] mem [NPHYS];

  // Read source select: 0 = zero, 1 = write bypass, 2 = array.
  function automatic logic [1:0] src_sel(input logic we,
                                         input logic [PW-1:0] widx,
                                         input logic [PW-1:0] ridx);
    if (ridx == '0 || int'(ridx) >= NPHYS) return 2'd0;
    if (we && widx == ridx) return 2'd1;
    return 2'd2;
  endfunction

  logic [1:0] sel_a, sel_b;
  assign sel_a = src_sel(wr_en, wr_idx, rd_a_idx);
  assign sel_b = src_sel(wr_en, wr_idx, rd_b_idx);

  always_comb begin
    case (sel_a)
      2'd1:    rd_a_data = wr_data;
      2'd2:    rd_a_data = mem[rd_a_idx];
      default: rd_a_data = '0;
    endcase
  end

  always_comb begin
    case (sel_b)
      2'd1:    rd_b_data = wr_data;
      2'd2:    rd_b_data = mem[rd_b_idx];
      default: rd_b_data = '0;
    endcase
  end

  logic wr_go;
  assign wr_go = wr_en && wr_idx != '0 && int'(wr_idx) < NPHYS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
    end else if (wr_go) begin
      mem[wr_idx] <= wr_data;
    end
  end

  // R12
  bypass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_a_idx && wr_idx != '0) |-> rd_a_data == wr_data);

  // R12
  bypass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_b_idx && wr_idx != '0) |-> rd_b_data == wr_data);

endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_req,
  input  logic          ret_req,
  input  logic          spill_ack,
  input  logic          fill_ack,
  output logic [CW-1:0] cwp,
  output logic [CW-1:0] swp,
  output logic          ovf_trap,
  output logic          unf_trap,
  output logic [CW-1:0] trap_win
);
  localparam int RW     = CW + 1;
  localparam int MAXRES = NWIN - 1;

  logic [RW-1:0] resident, eff, res_n;
  logic [CW-1:0] cwp_n, swp_n;
  win_evt_t      ev;

  function automatic logic [CW-1:0] ring_step(input logic [CW-1:0] p,
                                              input logic up, input logic dn);
    return p + CW'(up) - CW'(dn);
  endfunction

  // Acknowledges are settled first; call/return are judged on the result.
  always_comb begin
    ev.spill_ok = spill_ack && !fill_ack && resident > RW'(1);
    ev.fill_ok  = fill_ack && !spill_ack && resident < RW'(MAXRES);
    eff         = resident - RW'(ev.spill_ok) + RW'(ev.fill_ok);
    ev.call_ok  = call_req && !ret_req && eff < RW'(MAXRES);
    ev.ovf_hit  = call_req && !ret_req && eff == RW'(MAXRES);
    ev.ret_ok   = ret_req && !call_req && eff > RW'(1);
    ev.unf_hit  = ret_req && !call_req && eff == RW'(1);
    res_n       = eff + RW'(ev.call_ok) - RW'(ev.ret_ok);
    swp_n       = ring_step(swp, ev.spill_ok, ev.fill_ok);
    cwp_n       = ring_step(cwp, ev.call_ok, ev.ret_ok);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp      <= '0;
      swp      <= '0;
      resident <= RW'(1);
      ovf_trap <= 1'b0;
      unf_trap <= 1'b0;
      trap_win <= '0;
    end else begin
      cwp      <= cwp_n;
      swp      <= swp_n;
      resident <= res_n;
      ovf_trap <= ev.ovf_hit;
      unf_trap <= ev.unf_hit;
      if (ev.ovf_hit)      trap_win <= swp_n;
      else if (ev.unf_hit) trap_win <= cwp - CW'(1);
    end
  end

  // R7
  resident_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resident >= RW'(1) && resident <= RW'(MAXRES));

  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> (cwp == $past(cwp) && $past(call_req)));

  // R9
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_trap |-> (cwp == $past(cwp) && $past(ret_req)));

  // R5
  cwp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cwp == $past(cwp)) || (cwp == $past(cwp) + CW'(1)) || (cwp == $past(cwp) - CW'(1)));

  // R11
  both_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && ret_req) |=> ($stable(cwp) && !ovf_trap && !unf_trap));

  // R7
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_trap, unf_trap}));

endmodule

// File: rtl/rwin_file.sv
module rwin_file #(
  parameter int NWIN = 8,
  parameter int AREA = 8,
  parameter int DW   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(4*AREA)-1:0] rd_a_addr,
  output logic [DW-1:0]             rd_a_data,
  input  logic [$clog2(4*AREA)-1:0] rd_b_addr,
  output logic [DW-1:0]             rd_b_data,
  input  logic                      wr_en,
  input  logic [$clog2(4*AREA)-1:0] wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic                      call_req,
  input  logic                      ret_req,
  input  logic                      spill_ack,
  input  logic                      fill_ack,
  output logic                      ovf_trap,
  output logic                      unf_trap,
  output logic [$clog2(NWIN)-1:0]   trap_win,
  output logic [$clog2(NWIN)-1:0]   cwp_o,
  output logic [$clog2(NWIN)-1:0]   swp_o
);
  localparam int CW       = $clog2(NWIN);
  localparam int AW       = $clog2(4*AREA);
  localparam int WIN_PHYS = NWIN*2*AREA;
  localparam int NPHYS    = AREA + WIN_PHYS;
  localparam int PW       = $clog2(NPHYS);
  localparam int NPORT    = 3;   // read A, read B, write

  logic [CW-1:0] cwp, swp;
  logic [AW-1:0] xa [NPORT];
  logic [PW-1:0] xp [NPORT];

  assign xa[0] = rd_a_addr;
  assign xa[1] = rd_b_addr;
  assign xa[2] = wr_addr;

  for (genvar g = 0; g < NPORT; g++) begin : g_xlate
    rwin_xlate #(.NWIN(NWIN), .AREA(AREA), .CW(CW), .AW(AW), .PW(PW)) xlate_i (
      .cwp       (cwp),
      .arch_addr (xa[g]),
      .phys_idx  (xp[g])
    );
  end

  rwin_ctrl #(.NWIN(NWIN), .CW(CW)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .call_req  (call_req),
    .ret_req   (ret_req),
    .spill_ack (spill_ack),
    .fill_ack  (fill_ack),
    .cwp       (cwp),
    .swp       (swp),
    .ovf_trap  (ovf_trap),
    .unf_trap  (unf_trap),
    .trap_win  (trap_win)
  );

  rwin_store #(.DW(DW), .NPHYS(NPHYS), .PW(PW)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (xp[2]),
    .wr_data   (wr_data),
    .rd_a_idx  (xp[0]),
    .rd_b_idx  (xp[1]),
    .rd_a_data (rd_a_data),
    .rd_b_data (rd_b_data)
  );

  assign cwp_o = cwp;
  assign swp_o = swp;

endmodule

// File: tb/rwin_file_tb.sv
module rwin_file_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, call_req = 1'b0, ret_req = 1'b0;
  logic        spill_ack = 1'b0, fill_ack = 1'b0;
  logic        ovf_trap, unf_trap;
  logic [2:0]  trap_win, cwp_o, swp_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  rwin_file dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .call_req(call_req), .ret_req(ret_req),
    .spill_ack(spill_ack), .fill_ack(fill_ack),
    .ovf_trap(ovf_trap), .unf_trap(unf_trap), .trap_win(trap_win),
    .cwp_o(cwp_o), .swp_o(swp_o)
  );

  // {call, ret, spill, fill, exp_cwp, exp_swp, exp_ovf, exp_unf, exp_win}
  function automatic logic [14:0] v(input logic c, input logic r,
                                    input logic s, input logic f,
                                    input int ec, input int es,
                                    input logic eo, input logic eu,
                                    input int ew);
    return {c, r, s, f, 3'(ec), 3'(es), eo, eu, 3'(ew)};
  endfunction

  localparam int NV = 25;
  localparam logic [14:0] VEC [NV] = '{
    v(1,0,0,0, 1,0, 0,0, 0), v(1,0,0,0, 2,0, 0,0, 0),
    v(1,0,0,0, 3,0, 0,0, 0), v(1,0,0,0, 4,0, 0,0, 0),
    v(1,0,0,0, 5,0, 0,0, 0), v(1,0,0,0, 6,0, 0,0, 0),
    v(1,0,0,0, 6,0, 1,0, 0),   // R7 full: refused, oldest = 0
    v(0,0,1,0, 6,1, 0,0, 0),   // R8 spill
    v(1,0,0,0, 7,1, 0,0, 0),
    v(1,0,1,0, 0,2, 0,0, 0),   // R10 call with spill at full
    v(1,1,0,0, 0,2, 0,0, 0),   // R11 call+return ignored
    v(0,0,1,1, 0,2, 0,0, 0),   // R11 spill+fill ignored
    v(0,1,0,0, 7,2, 0,0, 0), v(0,1,0,0, 6,2, 0,0, 0),
    v(0,1,0,0, 5,2, 0,0, 0), v(0,1,0,0, 4,2, 0,0, 0),
    v(0,1,0,0, 3,2, 0,0, 0), v(0,1,0,0, 2,2, 0,0, 0),
    v(0,1,0,0, 2,2, 0,1, 1),   // R9 underflow, window 1
    v(0,0,1,0, 2,2, 0,0, 1),   // R8 spill ignored at one resident
    v(0,0,0,1, 2,1, 0,0, 1),   // R8 fill
    v(0,1,0,0, 1,1, 0,0, 1),
    v(0,1,0,1, 0,0, 0,0, 1),   // R10 return with fill at one resident
    v(0,0,0,1, 0,7, 0,0, 1),   // R8 fill wraps
    v(0,1,0,0, 7,7, 0,0, 1)    // R5 return wraps
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic c, input logic r, input logic s, input logic f);
    @(negedge clk);
    call_req = c; ret_req = r; spill_ack = s; fill_ack = f;
    @(posedge clk); #1;
    call_req = 1'b0; ret_req = 1'b0; spill_ack = 1'b0; fill_ack = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input bit port_b, input logic [4:0] a,
                    input logic [31:0] exp, input string tag);
    @(negedge clk);
    if (port_b) rd_b_addr = a; else rd_a_addr = a;
    #1;
    chk(tag, port_b ? rd_b_data : rd_a_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk); #1;
    chk("R1 cwp", 32'(cwp_o), 0);
    chk("R1 swp", 32'(swp_o), 0);
    chk("R1 traps", 32'({ovf_trap, unf_trap}), 0);
    rd(0, 5'd5, 32'h0, "R1 reg5 cleared");
    rd(1, 5'd20, 32'h0, "R1 reg20 cleared");

    wr(5'd0, 32'hDEAD_BEEF);
    rd(0, 5'd0, 32'h0, "R2 reg0 zero");
    rd(1, 5'd0, 32'h0, "R2 reg0 zero port b");

    // R12 write-through on both ports in the writing cycle
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'h1234_5678;
    rd_a_addr = 5'd9; rd_b_addr = 5'd9;
    #1;
    chk("R12 bypass a", rd_a_data, 32'h1234_5678);
    chk("R12 bypass b", rd_b_data, 32'h1234_5678);
    @(posedge clk); #1;
    wr_en = 1'b0;

    wr(5'd3,  32'h0000_0333);
    wr(5'd24, 32'h0000_0A24);
    wr(5'd16, 32'h0000_0016);
    step(1, 0, 0, 0);
    chk("R5 call", 32'(cwp_o), 1);
    rd(0, 5'd3,  32'h0000_0333, "R3 global via window 1");
    rd(1, 5'd8,  32'h0000_0A24, "R4 caller out = callee in");
    rd(0, 5'd16, 32'h0, "R6 callee local fresh");
    rd(1, 5'd24, 32'h0, "R4 callee out untouched");
    wr(5'd16, 32'h0000_1116);
    wr(5'd8,  32'h0000_0B08);
    step(0, 1, 0, 0);
    chk("R5 return", 32'(cwp_o), 0);
    rd(0, 5'd16, 32'h0000_0016, "R6 caller local kept");
    rd(1, 5'd24, 32'h0000_0B08, "R4 callee in = caller out");
    rd(0, 5'd9,  32'h1234_5678, "R12 written value stored");

    // Vector walk: pointers, traps and the same-cycle cases (R7 R8 R9 R10 R11)
    do_reset();
    for (int i = 0; i < NV; i++) begin
      logic [14:0] e;
      e = VEC[i];
      step(e[14], e[13], e[12], e[11]);
      chk($sformatf("R5 cwp step %0d", i), 32'(cwp_o), 32'(e[10:8]));
      chk($sformatf("R8 swp step %0d", i), 32'(swp_o), 32'(e[7:5]));
      chk($sformatf("R7 ovf step %0d", i), 32'(ovf_trap), 32'(e[4]));
      chk($sformatf("R9 unf step %0d", i), 32'(unf_trap), 32'(e[3]));
      if (e[4] || e[3])
        chk($sformatf("R7 trap window step %0d", i), 32'(trap_win), 32'(e[2:0]));
    end

    // R13 ring wrap: outgoing of window 7 is incoming of window 0
    do_reset();
    wr(5'd8, 32'h0000_0808);
    for (int k = 0; k < 6; k++) step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    chk("R7 overflow before wrap", 32'(ovf_trap), 1);
    step(0, 0, 1, 0);
    step(1, 0, 0, 0);
    chk("R13 at window 7", 32'(cwp_o), 7);
    rd(0, 5'd24, 32'h0000_0808, "R13 wrap read");
    wr(5'd24, 32'h0000_7777);
    rd(1, 5'd24, 32'h0000_7777, "R13 wrap write");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule